// File: doc/BRIEF.md
# SDH Errored-Second Performance Monitor

This block sorts each one-second interval of a received digital signal into performance categories and keeps the running counters that belong to them. Once per second, a single-cycle strobe presents three values: the number of errored blocks seen in that second, the number of blocks expected in it, and a defect flag. The block decides whether the second is errored or severely errored. It also tracks whether the signal is available. The signal becomes unavailable after ten severely errored seconds in a row, and becomes available again after ten seconds in a row that are not severely errored.

Both availability transitions take effect from the first second of the ten-second run that triggers them. For this reason every per-second result waits in a ten-entry delay line, where its availability label can still change. Only when a result leaves the delay line is it added to the counters. There are five counters: errored seconds, severely errored seconds, background block errors, unavailable seconds, and runs of consecutive severely errored seconds. A synchronous clear empties the history and zeroes all five. Upstream logic reads the counters directly from the output ports.

Top module: `sdh_perf_mon`

## Requirements
- R1: After reset or a clear pulse, all five counters read zero, the unavailable flag is low, and no earlier second affects any later classification. A clear in the same cycle as a strobe wins, and that strobe's second is discarded.
- R2: A second is errored when its errored-block count is nonzero or when the second is severely errored. Each available errored second adds one to the errored-second counter.
- R3: A second is severely errored when the defect flag is high, or when the errored-block count is nonzero and errored×10 ≥ expected×3. A second with zero errored blocks and no defect is never severely errored, even when the expected count is zero.
- R4: An available second that is not severely errored adds its errored-block count to the background block counter. A severely errored second adds nothing to it.
- R5: Ten severely errored seconds in a row while available make the signal unavailable. All ten of those seconds count as unavailable, and every second committed while unavailable changes only the unavailable-second counter.
- R6: Ten non-severely-errored seconds in a row while unavailable make the signal available again. Those ten seconds are counted as available, with their errored, severe and background contributions. A severely errored second restarts that run.
- R7: A run of 2 to 9 severely errored available seconds adds one to the consecutive-run counter when the run is committed and ends. A run of length 1 adds nothing.
- R8: A second reaches the counters when the tenth strobe after its own one arrives. The counter outputs show the change in the cycle after that strobe.
- R9: Every counter saturates at its all-ones value instead of wrapping.
- R10: Cycles without a strobe or a clear leave all outputs unchanged.
- R11: The unavailable flag changes only in the cycle after the strobe that completes a ten-second run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of counters and history |
| sec_valid | input | 1 | One-cycle strobe marking a completed second |
| err_blocks | input | 16 | Errored blocks in the second |
| total_blocks | input | 16 | Blocks expected in the second |
| defect | input | 1 | A defect was present during the second |
| es_count | output | CNT_W | Errored seconds |
| ses_count | output | CNT_W | Severely errored seconds |
| bbe_count | output | CNT_W | Background block errors |
| uas_count | output | CNT_W | Unavailable seconds |
| cses_count | output | CNT_W | Runs of 2 to 9 severely errored seconds |
| unavailable | output | 1 | Current availability state, high when unavailable |

## Verification
The assertions assume that `sec_valid` is a single-cycle pulse, that the block inputs are stable while it is high, and that `rst` and `clr` are synchronous. The stimulus drives every input on the falling edge, holds each strobe for exactly one cycle, and leaves random idle gaps between seconds. A behavioural queue model predicts all outputs on every clock. Directed runs land exactly on the 30% boundary, the zero-total case, the ninth and tenth severe seconds, a severe second that breaks a recovery run, saturation, and a clear that coincides with a strobe.

// File: rtl/pm_pkg.sv
package pm_pkg;

    localparam int PM_BLK_W = 16;

    typedef logic [PM_BLK_W-1:0] blk_t;

    typedef enum logic {
        ST_AVAIL   = 1'b0,
        ST_UNAVAIL = 1'b1
    } pm_state_e;

    // Per-second classification result
    typedef struct packed {
        logic ses;
        logic es;
        blk_t bbe;
    } pm_sec_t;

    // One delay-line slot: valid bit, availability label, classification
    typedef struct packed {
        logic    vld;
        logic    unav;
        pm_sec_t cls;
    } pm_slot_t;

    // Division-free 30% test: err*10 >= tot*3
    function automatic pm_sec_t pm_classify(blk_t err, blk_t tot, logic dfct);
        pm_sec_t r;
        logic [PM_BLK_W+3:0] e10;
        logic [PM_BLK_W+3:0] t3;
        logic any_err;
        e10 = ({4'b0, err} << 3) + ({4'b0, err} << 1);
        t3  = ({4'b0, tot} << 1) + {4'b0, tot};
        any_err = (err != '0);
        r.ses = dfct || (any_err && (e10 >= t3));
        r.es  = r.ses || any_err;
        r.bbe = r.ses ? '0 : err;
        return r;
    endfunction

endpackage

// File: rtl/pm_classifier.sv
module pm_classifier
    import pm_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    sec_valid,
    input  blk_t    err_blocks,
    input  blk_t    total_blocks,
    input  logic    defect,
    output pm_sec_t cls
);

    always_comb begin
        cls = pm_classify(err_blocks, total_blocks, defect);
    end

    // R3: a defect always makes the second severely errored and errored
    a_r3_defect_is_ses: assert property (@(posedge clk) disable iff (rst)
        (sec_valid && defect) |-> (cls.ses && cls.es && cls.bbe == '0));

    // R3: no errors and no defect is never severe
    a_r3_clean_not_ses: assert property (@(posedge clk) disable iff (rst)
        (sec_valid && !defect && err_blocks == '0) |-> (!cls.ses && !cls.es));

endmodule

// File: rtl/pm_avail_window.sv
module pm_avail_window
    import pm_pkg::*;
#(
    parameter int WIN = 10
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    clr,
    input  logic    push,
    input  pm_sec_t new_cls,
    output logic    commit_v,
    output pm_sec_t commit_cls,
    output logic    commit_unav,
    output logic    unav_o
);

    localparam int RW = $clog2(WIN + 1);

    pm_state_e state_q;
    pm_state_e state_nx;
    logic [RW-1:0] run_q;
    logic [RW-1:0] run_inc;
    logic hit;
    logic flip;
    pm_slot_t slot_q [WIN];

    // A run counts severe seconds while available, clean ones while unavailable
    always_comb begin
        hit      = (state_q == ST_UNAVAIL) ? !new_cls.ses : new_cls.ses;
        run_inc  = hit ? run_q + 1'b1 : '0;
        flip     = (run_inc == RW'(WIN));
        state_nx = state_q;
        if (flip) begin
            state_nx = (state_q == ST_AVAIL) ? ST_UNAVAIL : ST_AVAIL;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            state_q <= ST_AVAIL;
            run_q   <= '0;
        end else if (push) begin
            state_q <= state_nx;
            run_q   <= flip ? '0 : run_inc;
        end
    end

    // Slot 0 newest, slot WIN-1 oldest; a flip relabels the whole window
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            for (int i = 0; i < WIN; i++) begin
                slot_q[i] <= '0;
            end
        end else if (push) begin
            slot_q[0].vld  <= 1'b1;
            slot_q[0].unav <= (state_nx == ST_UNAVAIL);
            slot_q[0].cls  <= new_cls;
            for (int i = 1; i < WIN; i++) begin
                slot_q[i].vld  <= slot_q[i-1].vld;
                slot_q[i].unav <= flip ? (state_nx == ST_UNAVAIL) : slot_q[i-1].unav;
                slot_q[i].cls  <= slot_q[i-1].cls;
            end
        end
    end

    always_comb begin
        commit_v    = push && slot_q[WIN-1].vld;
        commit_cls  = slot_q[WIN-1].cls;
        commit_unav = slot_q[WIN-1].unav;
        unav_o      = (state_q == ST_UNAVAIL);
    end

    // R6: run never rests at the transition length
    a_r6_run_bounded: assert property (@(posedge clk) disable iff (rst)
        run_q < RW'(WIN));

    // R11: state moves only on a strobe
    a_r11_state_on_strobe: assert property (@(posedge clk) disable iff (rst)
        (!push && !clr) |=> $stable(state_q));

    // R1: clear empties the history and returns to available
    a_r1_clear_empties: assert property (@(posedge clk) disable iff (rst)
        clr |=> (state_q == ST_AVAIL && run_q == '0 &&
                 !slot_q[0].vld && !slot_q[WIN-1].vld));

endmodule

// File: rtl/pm_counters.sv
module pm_counters
    import pm_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int WIN   = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             commit_v,
    input  pm_sec_t          commit_cls,
    input  logic             commit_unav,
    output logic [CNT_W-1:0] es_cnt,
    output logic [CNT_W-1:0] ses_cnt,
    output logic [CNT_W-1:0] bbe_cnt,
    output logic [CNT_W-1:0] uas_cnt,
    output logic [CNT_W-1:0] cses_cnt
);

    localparam int RW = $clog2(WIN + 1);
    localparam int SW = ((CNT_W > PM_BLK_W) ? CNT_W : PM_BLK_W) + 1;
    localparam logic [SW-1:0] MAX_S = SW'({CNT_W{1'b1}});

    logic [RW-1:0] crun_q;
    logic [SW-1:0] bbe_sum;
    logic [CNT_W-1:0] bbe_nx;
    logic run_ends;
    logic run_counts;

    function automatic logic [CNT_W-1:0] sat_inc(logic [CNT_W-1:0] v);
        return (v == '1) ? v : v + 1'b1;
    endfunction

    always_comb begin
        bbe_sum    = SW'(bbe_cnt) + SW'(commit_cls.bbe);
        bbe_nx     = (bbe_sum > MAX_S) ? '1 : bbe_sum[CNT_W-1:0];
        run_ends   = commit_unav || !commit_cls.ses;
        run_counts = (crun_q >= RW'(2)) && (crun_q < RW'(WIN));
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            es_cnt   <= '0;
            ses_cnt  <= '0;
            bbe_cnt  <= '0;
            uas_cnt  <= '0;
            cses_cnt <= '0;
            crun_q   <= '0;
        end else if (commit_v) begin
            if (commit_unav) begin
                uas_cnt <= sat_inc(uas_cnt);
            end else begin
                if (commit_cls.es)  es_cnt  <= sat_inc(es_cnt);
                if (commit_cls.ses) ses_cnt <= sat_inc(ses_cnt);
                bbe_cnt <= bbe_nx;
            end
            if (run_ends) begin
                crun_q <= '0;
                if (run_counts) cses_cnt <= sat_inc(cses_cnt);
            end else if (crun_q != RW'(WIN)) begin
                crun_q <= crun_q + 1'b1;
            end
        end
    end

    // R9: counters never wrap downward without a clear
    a_r9_es_no_wrap: assert property (@(posedge clk) disable iff (rst)
        !clr |=> es_cnt >= $past(es_cnt));
    a_r9_bbe_no_wrap: assert property (@(posedge clk) disable iff (rst)
        !clr |=> bbe_cnt >= $past(bbe_cnt));
    a_r9_uas_no_wrap: assert property (@(posedge clk) disable iff (rst)
        !clr |=> uas_cnt >= $past(uas_cnt));

    // R5: unavailable commits touch only the unavailable counter
    a_r5_inhibit: assert property (@(posedge clk) disable iff (rst)
        (commit_v && commit_unav && !clr) |=>
            ($stable(es_cnt) && $stable(ses_cnt) && $stable(bbe_cnt)));

    // R10: idle cycles change nothing
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!commit_v && !clr) |=> ($stable(es_cnt) && $stable(uas_cnt) && $stable(cses_cnt)));

    // R1: clear zeroes every counter
    a_r1_clear_zero: assert property (@(posedge clk) disable iff (rst)
        clr |=> (es_cnt == '0 && ses_cnt == '0 && bbe_cnt == '0 &&
                 uas_cnt == '0 && cses_cnt == '0));

endmodule

// File: rtl/sdh_perf_mon.sv
module sdh_perf_mon
    import pm_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int WIN   = 10
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clr,
    input  logic                sec_valid,
    input  logic [PM_BLK_W-1:0] err_blocks,
    input  logic [PM_BLK_W-1:0] total_blocks,
    input  logic                defect,
    output logic [CNT_W-1:0]    es_count,
    output logic [CNT_W-1:0]    ses_count,
    output logic [CNT_W-1:0]    bbe_count,
    output logic [CNT_W-1:0]    uas_count,
    output logic [CNT_W-1:0]    cses_count,
    output logic                unavailable
);

    pm_sec_t cls;
    pm_sec_t commit_cls;
    logic    commit_v;
    logic    commit_unav;
    logic    push;

    assign push = sec_valid && !clr;

    pm_classifier u_cls (
        .clk          (clk),
        .rst          (rst),
        .sec_valid    (sec_valid),
        .err_blocks   (err_blocks),
        .total_blocks (total_blocks),
        .defect       (defect),
        .cls          (cls)
    );

    pm_avail_window #(.WIN(WIN)) u_win (
        .clk         (clk),
        .rst         (rst),
        .clr         (clr),
        .push        (push),
        .new_cls     (cls),
        .commit_v    (commit_v),
        .commit_cls  (commit_cls),
        .commit_unav (commit_unav),
        .unav_o      (unavailable)
    );

    pm_counters #(.CNT_W(CNT_W), .WIN(WIN)) u_cnt (
        .clk         (clk),
        .rst         (rst),
        .clr         (clr),
        .commit_v    (commit_v),
        .commit_cls  (commit_cls),
        .commit_unav (commit_unav),
        .es_cnt      (es_count),
        .ses_cnt     (ses_count),
        .bbe_cnt     (bbe_count),
        .uas_cnt     (uas_count),
        .cses_cnt    (cses_count)
    );

endmodule

// File: tb/sdh_perf_mon_tb.sv
module sdh_perf_mon_tb;

    localparam int CLK_PERIOD = 10;
    localparam int CW  = 6;
    localparam int WIN = 10;
    localparam int LIM = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic clr = 1'b0;
    logic sec_valid = 1'b0;
    logic [15:0] err_blocks = '0;
    logic [15:0] total_blocks = '0;
    logic defect = 1'b0;
    logic [CW-1:0] es_count, ses_count, bbe_count, uas_count, cses_count;
    logic unavailable;

    int total = 0;
    int bad = 0;
    bit started = 0;

    sdh_perf_mon #(.CNT_W(CW), .WIN(WIN)) u_dut (
        .clk(clk), .rst(rst), .clr(clr), .sec_valid(sec_valid),
        .err_blocks(err_blocks), .total_blocks(total_blocks), .defect(defect),
        .es_count(es_count), .ses_count(ses_count), .bbe_count(bbe_count),
        .uas_count(uas_count), .cses_count(cses_count), .unavailable(unavailable)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference model
    typedef struct { bit ses; bit es; bit unav; int bbe; } ent_t;
    ent_t mq[$];
    int m_es, m_ses, m_bbe, m_uas, m_cses, m_run, m_crun;
    bit m_unav;

    function automatic int sat(int v);
        return (v > LIM) ? LIM : v;
    endfunction

    task automatic model_clear();
        mq.delete();
        m_es = 0; m_ses = 0; m_bbe = 0; m_uas = 0; m_cses = 0;
        m_run = 0; m_crun = 0; m_unav = 0;
    endtask

    task automatic model_commit(ent_t x);
        bit ends;
        if (x.unav) m_uas = sat(m_uas + 1);
        else begin
            if (x.es)  m_es  = sat(m_es + 1);
            if (x.ses) m_ses = sat(m_ses + 1);
            m_bbe = sat(m_bbe + x.bbe);
        end
        ends = x.unav || !x.ses;
        if (ends) begin
            if (m_crun >= 2 && m_crun <= 9) m_cses = sat(m_cses + 1);
            m_crun = 0;
        end else if (m_crun < WIN) m_crun++;
    endtask

    task automatic model_step(int e, int t, bit d);
        ent_t n;
        bit hit;
        n.ses = d || (e != 0 && e * 10 >= t * 3);
        n.es  = n.ses || (e != 0);
        n.bbe = n.ses ? 0 : e;
        n.unav = m_unav;
        if (mq.size() == WIN) model_commit(mq.pop_front());
        mq.push_back(n);
        hit = m_unav ? !n.ses : n.ses;
        m_run = hit ? m_run + 1 : 0;
        if (m_run == WIN) begin
            m_run = 0;
            m_unav = !m_unav;
            foreach (mq[i]) mq[i].unav = m_unav;
        end
    endtask

    task automatic chk(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Per-clock comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (started && !rst) begin
            chk("R2", "es_count",   int'(es_count),   m_es);
            chk("R3", "ses_count",  int'(ses_count),  m_ses);
            chk("R4", "bbe_count",  int'(bbe_count),  m_bbe);
            chk("R5", "uas_count",  int'(uas_count),  m_uas);
            chk("R7", "cses_count", int'(cses_count), m_cses);
            chk("R11", "unavailable", int'(unavailable), int'(m_unav));
        end
    end

    task automatic sec(int e, int t, bit d);
        err_blocks = 16'(e); total_blocks = 16'(t); defect = d; sec_valid = 1'b1;
        @(posedge clk);
        model_step(e, t, d);
        @(negedge clk);
        sec_valid = 1'b0; err_blocks = '0; defect = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_clear(bit with_strobe);
        clr = 1'b1; sec_valid = with_strobe; err_blocks = 16'd7; total_blocks = 16'd100;
        @(posedge clk);
        model_clear();
        @(negedge clk);
        clr = 1'b0; sec_valid = 1'b0; err_blocks = '0;
    endtask

    task automatic clean(int n);
        for (int i = 0; i < n; i++) sec(0, 100, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        started = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "reset es", int'(es_count), 0);
        chk("R1", "reset unavailable", int'(unavailable), 0);

        // R8: a second commits on the tenth strobe after it
        sec(5, 100, 0);
        clean(9);
        chk("R8", "es before commit", int'(es_count), 0);
        sec(0, 100, 0);
        chk("R8", "es after commit", int'(es_count), 1);
        chk("R8", "bbe after commit", int'(bbe_count), 5);

        // R3 boundaries: 29% clean, 30% severe, zero total, defect only
        sec(29, 100, 0);
        sec(30, 100, 0);
        sec(0, 0, 0);
        sec(0, 100, 1);
        clean(10);
        chk("R3", "ses boundary", int'(ses_count), 2);
        chk("R2", "es incl. ses", int'(es_count), 4);
        chk("R4", "bbe excludes ses", int'(bbe_count), 34);
        chk("R7", "single ses no run", int'(cses_count), 0);

        // R10 idle gap
        idle(5);
        chk("R10", "idle es", int'(es_count), 4);

        // R7 short run
        do_clear(1'b0);
        chk("R1", "clear es", int'(es_count), 0);
        for (int i = 0; i < 3; i++) sec(50, 100, 0);
        clean(11);
        chk("R7", "run of 3", int'(cses_count), 1);

        // R5/R6/R11 unavailable entry and exit
        do_clear(1'b0);
        for (int i = 0; i < 9; i++) sec(60, 100, 0);
        chk("R11", "ninth ses still available", int'(unavailable), 0);
        sec(60, 100, 0);
        chk("R11", "tenth ses unavailable", int'(unavailable), 1);
        sec(60, 100, 0); sec(0, 100, 1);
        clean(4);
        sec(40, 100, 0);
        clean(9);
        chk("R6", "nine clean still unavailable", int'(unavailable), 1);
        sec(3, 100, 0);
        chk("R6", "tenth clean available", int'(unavailable), 0);
        clean(10);
        chk("R5", "uas total", int'(uas_count), 17);
        chk("R5", "ses inhibited", int'(ses_count), 0);
        chk("R6", "recovery seconds counted", int'(es_count), 1);
        chk("R6", "recovery bbe", int'(bbe_count), 3);

        // R7: run of nine stays available
        for (int i = 0; i < 9; i++) sec(80, 100, 0);
        chk("R5", "nine ses available", int'(unavailable), 0);
        clean(11);
        chk("R7", "run of 9", int'(cses_count), 1);
        chk("R3", "nine ses counted", int'(ses_count), 9);

        // R1: clear coinciding with a strobe discards it
        do_clear(1'b1);
        clean(10);
        chk("R1", "strobe during clear dropped", int'(bbe_count), 0);

        // R9 saturation
        for (int i = 0; i < 80; i++) sec(20, 100, 0);
        clean(10);
        chk("R9", "bbe saturates", int'(bbe_count), LIM);
        chk("R9", "es saturates", int'(es_count), LIM);

        // Mixed random traffic
        begin
            int mode = 0;
            for (int i = 0; i < 4000; i++) begin
                if ($urandom % 40 == 0) mode = $urandom % 2;
                if ($urandom % 600 == 0) do_clear($urandom % 2 == 0);
                if (mode == 1 && $urandom % 100 < 85) begin
                    if ($urandom % 4 == 0) sec(0, 100, 1);
                    else sec(30 + $urandom % 71, 100, 0);
                end else if ($urandom % 4 == 0) begin
                    sec($urandom % 40, 100, 0);
                end else begin
                    sec(0, 100, 0);
                end
                idle($urandom % 3);
            end
        end

        idle(2);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule